// File: doc/BRIEF.md
# Branchless 8-bit Execution Unit with Flags

This block is the execute stage of a very small processor that has no branches, no memory port and no instruction fetch. It owns a file of 26 eight-bit registers and two status flags: zero and carry. Instructions arrive one at a time on an issue port. Each instruction carries an opcode, a destination register, and a second operand. The second operand is either a register or an 8-bit immediate. The unit computes the result, writes it back, and updates the flags. Arithmetic, logic, shift, rotate, nibble-swap, register-exchange and flag-materialising operations are all handled.

Every opcode has a fixed latency of one, two or three cycles. While an instruction is in flight the unit reports busy and refuses new work. The register write and the flag update happen at the clock edge that closes the cycle in which the one-cycle `done` pulse is high. A read-only peek port exposes any register combinationally, so surrounding logic or a test environment can observe the register file.

Top module: `alu8_core`

## Requirements
- R1: After reset every register reads 0x00, both flags are 0, and `busy` and `done` are low.
- R2: Opcode encoding (5 bits): 0 move, 1 exchange, 2 nibble swap, 3/4/5/6 set-one on Z/NZ/C/NC, 7/8/9/10 fill-ones on Z/NZ/C/NC, 11 add, 12 subtract, 13 add with carry, 14 subtract with borrow, 15 and, 16 or, 17 xor, 18 shift right, 19 shift left, 20 rotate right, 21 rotate left, 22 rotate right through carry, 23 rotate left through carry, 24 invert, 25 negate. With acceptance at edge E, `done` is high in cycle number L after E, for exactly one cycle. L is 1 for codes 0, 3–10 and 18–21; L is 3 for codes 13 and 14; L is 2 for all other defined codes. Codes 26–31 take one cycle and change neither registers nor flags.
- R3: An instruction is accepted only when `in_valid` is high and `in_ready` is high. `in_ready` is low while `busy` is high. An instruction presented while busy has no effect.
- R4: Move, and, or, xor and invert write the expected value and set Z when the result is zero. They leave C unchanged.
- R5: Add and add-with-carry set C on a carry out of bit 7. Subtract and subtract-with-borrow set C on a borrow. The with-carry forms add or subtract the incoming C.
- R6: Shift right and shift left fill the vacated bit with zero. Rotate right and rotate left move the bit leaving one end into the other end. In all four cases C receives the bit that left the register: bit 0 for rightward moves, bit 7 for leftward moves.
- R7: The two through-carry rotates put the old C into the vacated end and the departing bit into C.
- R8: Nibble swap exchanges bits 7:4 with bits 3:0. Exchange writes the source value into the destination and the destination value into the source. Z follows the new destination value and C is unchanged. Exchange always takes its second operand from a register, even when the immediate select is set.
- R9: Set-one ops write 0x01 when the condition holds and 0x00 otherwise. They update Z from that value and leave C unchanged.
- R10: Fill-ones ops write 0xFF when the condition holds and 0x00 otherwise. They leave both flags unchanged.
- R11: Negate writes the two's complement of the destination, updates Z from it, and sets C to the inverse of the new Z.
- R12: When `in_use_imm` is high, two-operand ops other than exchange take `in_imm` as the second operand. Single-operand ops ignore both `in_src` and `in_imm`.
- R13: Registers and flags change only at the edge that ends a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented |
| in_ready | output | 1 | Unit can accept an instruction this cycle |
| in_op | input | 5 | Opcode (R2 encoding) |
| in_dst | input | 5 | Destination / single operand register index |
| in_use_imm | input | 1 | Select immediate as second operand |
| in_src | input | 5 | Second operand register index |
| in_imm | input | 8 | Immediate second operand |
| busy | output | 1 | An instruction is in flight |
| done | output | 1 | Final cycle of the instruction in flight |
| zf | output | 1 | Zero flag |
| cf | output | 1 | Carry flag |
| peek_addr | input | 5 | Register index to observe |
| peek_data | output | 8 | Contents of register `peek_addr` |

## Verification
For an instruction accepted at edge E, `done` rises in cycle L after E, where L is one, two or three depending on the opcode. The new register values and flags are visible only after the next edge. The bench drives inputs on falling edges and counts falling edges from acceptance until it sees `done`, then compares that count with L. It samples registers through the peek port, and the flags, one falling edge after the `done` cycle. It also confirms that an instruction offered in the middle of a busy window never lands in the register file.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_MOVE   = 5'd0,
        OP_XCHG   = 5'd1,
        OP_NIBSW  = 5'd2,
        OP_ONE_Z  = 5'd3,
        OP_ONE_NZ = 5'd4,
        OP_ONE_C  = 5'd5,
        OP_ONE_NC = 5'd6,
        OP_FILL_Z  = 5'd7,
        OP_FILL_NZ = 5'd8,
        OP_FILL_C  = 5'd9,
        OP_FILL_NC = 5'd10,
        OP_ADD    = 5'd11,
        OP_SUB    = 5'd12,
        OP_ADDC   = 5'd13,
        OP_SUBB   = 5'd14,
        OP_AND    = 5'd15,
        OP_OR     = 5'd16,
        OP_XOR    = 5'd17,
        OP_SHR    = 5'd18,
        OP_SHL    = 5'd19,
        OP_ROTR   = 5'd20,
        OP_ROTL   = 5'd21,
        OP_ROTRC  = 5'd22,
        OP_ROTLC  = 5'd23,
        OP_INV    = 5'd24,
        OP_NEG    = 5'd25
    } op_e;

    typedef enum logic [1:0] {
        LAT_SHORT = 2'd0,
        LAT_MID   = 2'd1,
        LAT_LONG  = 2'd2
    } lat_e;

    function automatic lat_e lat_class(input logic [OPW-1:0] op);
        lat_e c;
        case (op)
            OP_MOVE, OP_ONE_Z, OP_ONE_NZ, OP_ONE_C, OP_ONE_NC,
            OP_FILL_Z, OP_FILL_NZ, OP_FILL_C, OP_FILL_NC,
            OP_SHR, OP_SHL, OP_ROTR, OP_ROTL:             c = LAT_SHORT;
            OP_ADDC, OP_SUBB:                              c = LAT_LONG;
            OP_XCHG, OP_NIBSW, OP_ADD, OP_SUB, OP_AND, OP_OR,
            OP_XOR, OP_ROTRC, OP_ROTLC, OP_INV, OP_NEG:    c = LAT_MID;
            default:                                       c = LAT_SHORT;
        endcase
        return c;
    endfunction

    function automatic logic is_fill(input logic [OPW-1:0] op);
        return (op == OP_FILL_Z) || (op == OP_FILL_NZ) ||
               (op == OP_FILL_C) || (op == OP_FILL_NC);
    endfunction

    function automatic logic is_one(input logic [OPW-1:0] op);
        return (op == OP_ONE_Z) || (op == OP_ONE_NZ) ||
               (op == OP_ONE_C) || (op == OP_ONE_NC);
    endfunction

endpackage

// File: rtl/alu8_seq.sv
module alu8_seq
    import alu8_pkg::*;
#(
    parameter int AW       = 5,
    parameter int DW       = 8,
    parameter int LAT_ONE  = 1,
    parameter int LAT_TWO  = 2,
    parameter int LAT_THREE = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [OPW-1:0] in_op,
    input  logic [AW-1:0]  in_dst,
    input  logic           in_use_imm,
    input  logic [AW-1:0]  in_src,
    input  logic [DW-1:0]  in_imm,
    output logic           in_ready,
    output logic           busy,
    output logic           done,
    output logic [OPW-1:0] cur_op,
    output logic [AW-1:0]  cur_dst,
    output logic           cur_use_imm,
    output logic [AW-1:0]  cur_src,
    output logic [DW-1:0]  cur_imm
);

    localparam int LAT_MAX = (LAT_THREE > LAT_TWO) ?
                             ((LAT_THREE > LAT_ONE) ? LAT_THREE : LAT_ONE) :
                             ((LAT_TWO > LAT_ONE) ? LAT_TWO : LAT_ONE);
    localparam int CW = $clog2(LAT_MAX + 1);

    typedef struct packed {
        logic           busy;
        logic [CW-1:0]  cnt;
        logic [OPW-1:0] op;
        logic [AW-1:0]  dst;
        logic           use_imm;
        logic [AW-1:0]  src;
        logic [DW-1:0]  imm;
    } seq_t;

    seq_t seq_d, seq_q;
    logic accept;

    always_comb begin
        seq_d  = seq_q;
        accept = in_valid && !seq_q.busy;
        if (seq_q.busy) begin
            seq_d.cnt = seq_q.cnt - CW'(1);
            if (seq_q.cnt == CW'(1)) begin
                seq_d.busy = 1'b0;
            end
        end else if (accept) begin
            seq_d.busy    = 1'b1;
            seq_d.op      = in_op;
            seq_d.dst     = in_dst;
            seq_d.use_imm = in_use_imm;
            seq_d.src     = in_src;
            seq_d.imm     = in_imm;
            case (lat_class(in_op))
                LAT_LONG: seq_d.cnt = CW'(LAT_THREE);
                LAT_MID:  seq_d.cnt = CW'(LAT_TWO);
                default:  seq_d.cnt = CW'(LAT_ONE);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign in_ready    = !seq_q.busy;
    assign busy        = seq_q.busy;
    assign done        = seq_q.busy && (seq_q.cnt == CW'(1));
    assign cur_op      = seq_q.op;
    assign cur_dst     = seq_q.dst;
    assign cur_use_imm = seq_q.use_imm;
    assign cur_src     = seq_q.src;
    assign cur_imm     = seq_q.imm;

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R3
    busy_from_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_valid));

endmodule

// File: rtl/alu8_exec.sv
module alu8_exec
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  opa,
    input  logic [DW-1:0]  opb,
    input  logic           zf_in,
    input  logic           cf_in,
    output logic           wr_a,
    output logic [DW-1:0]  res_a,
    output logic           wr_b,
    output logic [DW-1:0]  res_b,
    output logic           zf_out,
    output logic           cf_out
);

    localparam int HALF = DW / 2;

    logic          upd_z;
    logic [DW:0]   wide;
    logic [DW:0]   cin_ext;

    always_comb begin
        wr_a    = 1'b1;
        wr_b    = 1'b0;
        res_a   = opa;
        res_b   = opb;
        upd_z   = 1'b1;
        cf_out  = cf_in;
        zf_out  = zf_in;
        cin_ext = {{DW{1'b0}}, cf_in};
        wide    = '0;
        case (op)
            OP_MOVE:    res_a = opb;
            OP_XCHG: begin
                res_a = opb;
                res_b = opa;
                wr_b  = 1'b1;
            end
            OP_NIBSW:   res_a = {opa[HALF-1:0], opa[DW-1:HALF]};
            OP_ONE_Z:   res_a = {{(DW-1){1'b0}}, zf_in};
            OP_ONE_NZ:  res_a = {{(DW-1){1'b0}}, !zf_in};
            OP_ONE_C:   res_a = {{(DW-1){1'b0}}, cf_in};
            OP_ONE_NC:  res_a = {{(DW-1){1'b0}}, !cf_in};
            OP_FILL_Z: begin
                res_a = {DW{zf_in}};
                upd_z = 1'b0;
            end
            OP_FILL_NZ: begin
                res_a = {DW{!zf_in}};
                upd_z = 1'b0;
            end
            OP_FILL_C: begin
                res_a = {DW{cf_in}};
                upd_z = 1'b0;
            end
            OP_FILL_NC: begin
                res_a = {DW{!cf_in}};
                upd_z = 1'b0;
            end
            OP_ADD: begin
                wide   = {1'b0, opa} + {1'b0, opb};
                res_a  = wide[DW-1:0];
                cf_out = wide[DW];
            end
            OP_SUB: begin
                wide   = {1'b0, opa} - {1'b0, opb};
                res_a  = wide[DW-1:0];
                cf_out = wide[DW];
            end
            OP_ADDC: begin
                wide   = {1'b0, opa} + {1'b0, opb} + cin_ext;
                res_a  = wide[DW-1:0];
                cf_out = wide[DW];
            end
            OP_SUBB: begin
                wide   = {1'b0, opa} - {1'b0, opb} - cin_ext;
                res_a  = wide[DW-1:0];
                cf_out = wide[DW];
            end
            OP_AND:     res_a = opa & opb;
            OP_OR:      res_a = opa | opb;
            OP_XOR:     res_a = opa ^ opb;
            OP_SHR: begin
                res_a  = {1'b0, opa[DW-1:1]};
                cf_out = opa[0];
            end
            OP_SHL: begin
                res_a  = {opa[DW-2:0], 1'b0};
                cf_out = opa[DW-1];
            end
            OP_ROTR: begin
                res_a  = {opa[0], opa[DW-1:1]};
                cf_out = opa[0];
            end
            OP_ROTL: begin
                res_a  = {opa[DW-2:0], opa[DW-1]};
                cf_out = opa[DW-1];
            end
            OP_ROTRC: begin
                res_a  = {cf_in, opa[DW-1:1]};
                cf_out = opa[0];
            end
            OP_ROTLC: begin
                res_a  = {opa[DW-2:0], cf_in};
                cf_out = opa[DW-1];
            end
            OP_INV:     res_a = ~opa;
            OP_NEG: begin
                res_a  = (~opa) + DW'(1);
                cf_out = (res_a != '0);
            end
            default: begin
                wr_a  = 1'b0;
                upd_z = 1'b0;
            end
        endcase
        if (upd_z) begin
            zf_out = (res_a == '0);
        end
    end

endmodule

// File: rtl/alu8_regfile.sv
module alu8_regfile #(
    parameter int NREG = 26,
    parameter int DW   = 8,
    parameter int AW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wa_en,
    input  logic [AW-1:0] wa_addr,
    input  logic [DW-1:0] wa_data,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [DW-1:0] wb_data,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data,
    input  logic [AW-1:0] rp_addr,
    output logic [DW-1:0] rp_data
);

    logic [NREG-1:0][DW-1:0] file_q;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [DW-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (wb_en && (wb_addr == AW'(i))) begin
                val_d = wb_data;
            end
            if (wa_en && (wa_addr == AW'(i))) begin
                val_d = wa_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
            end else begin
                val_q <= val_d;
            end
        end

        assign file_q[i] = val_q;
    end

    assign ra_data = (ra_addr < AW'(NREG)) ? file_q[ra_addr] : '0;
    assign rb_data = (rb_addr < AW'(NREG)) ? file_q[rb_addr] : '0;
    assign rp_data = (rp_addr < AW'(NREG)) ? file_q[rp_addr] : '0;

    // R8
    xchg_same_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wb_en && (wa_addr == wb_addr)) |-> (wa_data == wb_data));

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter  int REG_COUNT = 26,
    parameter  int DW        = 8,
    parameter  int LAT_ONE   = 1,
    parameter  int LAT_TWO   = 2,
    parameter  int LAT_THREE = 3,
    localparam int AW        = $clog2(REG_COUNT)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [OPW-1:0] in_op,
    input  logic [AW-1:0]  in_dst,
    input  logic           in_use_imm,
    input  logic [AW-1:0]  in_src,
    input  logic [DW-1:0]  in_imm,
    output logic           busy,
    output logic           done,
    output logic           zf,
    output logic           cf,
    input  logic [AW-1:0]  peek_addr,
    output logic [DW-1:0]  peek_data
);

    typedef struct packed {
        logic zf;
        logic cf;
    } flags_t;

    flags_t fl_d, fl_q;

    logic [OPW-1:0] cur_op;
    logic [AW-1:0]  cur_dst, cur_src;
    logic           cur_use_imm;
    logic [DW-1:0]  cur_imm;
    logic [DW-1:0]  rf_a, rf_b, opb;
    logic           wr_a, wr_b, zf_n, cf_n;
    logic [DW-1:0]  res_a, res_b;

    alu8_seq #(
        .AW(AW), .DW(DW),
        .LAT_ONE(LAT_ONE), .LAT_TWO(LAT_TWO), .LAT_THREE(LAT_THREE)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_op       (in_op),
        .in_dst      (in_dst),
        .in_use_imm  (in_use_imm),
        .in_src      (in_src),
        .in_imm      (in_imm),
        .in_ready    (in_ready),
        .busy        (busy),
        .done        (done),
        .cur_op      (cur_op),
        .cur_dst     (cur_dst),
        .cur_use_imm (cur_use_imm),
        .cur_src     (cur_src),
        .cur_imm     (cur_imm)
    );

    alu8_regfile #(.NREG(REG_COUNT), .DW(DW), .AW(AW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wa_en   (done && wr_a),
        .wa_addr (cur_dst),
        .wa_data (res_a),
        .wb_en   (done && wr_b),
        .wb_addr (cur_src),
        .wb_data (res_b),
        .ra_addr (cur_dst),
        .ra_data (rf_a),
        .rb_addr (cur_src),
        .rb_data (rf_b),
        .rp_addr (peek_addr),
        .rp_data (peek_data)
    );

    // the exchange op always reads its partner from the register file
    assign opb = (cur_use_imm && (cur_op != OP_XCHG)) ? cur_imm : rf_b;

    alu8_exec #(.DW(DW)) u_exec (
        .op     (cur_op),
        .opa    (rf_a),
        .opb    (opb),
        .zf_in  (fl_q.zf),
        .cf_in  (fl_q.cf),
        .wr_a   (wr_a),
        .res_a  (res_a),
        .wr_b   (wr_b),
        .res_b  (res_b),
        .zf_out (zf_n),
        .cf_out (cf_n)
    );

    always_comb begin
        fl_d = fl_q;
        if (done) begin
            fl_d.zf = zf_n;
            fl_d.cf = cf_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign zf = fl_q.zf;
    assign cf = fl_q.cf;

    // R13
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(zf) && $stable(cf)));

    // R10
    fill_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && is_fill(cur_op)) |=> ($stable(zf) && $stable(cf)));

    // R11
    neg_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cur_op == OP_NEG)) |=> (cf == !zf));

    // R9
    one_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && is_one(cur_op)) |=> $stable(cf));

endmodule

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;

    localparam int NR = 26;
    localparam int NV = 43;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [4:0] in_op = '0;
    logic [4:0] in_dst = '0;
    logic       in_use_imm = 1'b0;
    logic [4:0] in_src = '0;
    logic [7:0] in_imm = '0;
    logic       busy, done, zf, cf;
    logic [4:0] peek_addr = '0;
    logic [7:0] peek_data;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    logic [7:0] m_reg [NR];
    bit m_zf, m_cf;

    always #5 clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_dst(in_dst), .in_use_imm(in_use_imm),
        .in_src(in_src), .in_imm(in_imm), .busy(busy), .done(done),
        .zf(zf), .cf(cf), .peek_addr(peek_addr), .peek_data(peek_data)
    );

    // {op, dst, use_imm, src, imm}
    localparam logic [23:0] VEC [NV] = '{
        {5'd0,  5'd0,  1'b1, 5'd0,  8'h5A},
        {5'd0,  5'd1,  1'b1, 5'd0,  8'hC3},
        {5'd11, 5'd0,  1'b0, 5'd1,  8'h00},
        {5'd13, 5'd0,  1'b1, 5'd0,  8'h00},
        {5'd12, 5'd2,  1'b1, 5'd0,  8'h01},
        {5'd14, 5'd2,  1'b1, 5'd0,  8'hFE},
        {5'd3,  5'd3,  1'b0, 5'd0,  8'h00},
        {5'd6,  5'd4,  1'b0, 5'd0,  8'h00},
        {5'd9,  5'd5,  1'b0, 5'd0,  8'h00},
        {5'd11, 5'd1,  1'b0, 5'd1,  8'h00},
        {5'd9,  5'd6,  1'b0, 5'd0,  8'h00},
        {5'd5,  5'd7,  1'b0, 5'd0,  8'h00},
        {5'd8,  5'd8,  1'b0, 5'd0,  8'h00},
        {5'd7,  5'd13, 1'b0, 5'd0,  8'h00},
        {5'd10, 5'd14, 1'b0, 5'd0,  8'h00},
        {5'd4,  5'd15, 1'b0, 5'd0,  8'h00},
        {5'd18, 5'd1,  1'b1, 5'd0,  8'hFF},
        {5'd19, 5'd1,  1'b0, 5'd2,  8'h00},
        {5'd19, 5'd1,  1'b0, 5'd0,  8'h00},
        {5'd22, 5'd1,  1'b0, 5'd0,  8'h00},
        {5'd23, 5'd1,  1'b0, 5'd0,  8'h00},
        {5'd20, 5'd0,  1'b0, 5'd0,  8'h00},
        {5'd20, 5'd0,  1'b0, 5'd0,  8'h00},
        {5'd21, 5'd0,  1'b0, 5'd0,  8'h00},
        {5'd2,  5'd0,  1'b1, 5'd3,  8'hAA},
        {5'd15, 5'd0,  1'b1, 5'd0,  8'h3C},
        {5'd16, 5'd0,  1'b0, 5'd2,  8'h00},
        {5'd17, 5'd0,  1'b1, 5'd0,  8'h30},
        {5'd24, 5'd0,  1'b1, 5'd0,  8'h55},
        {5'd25, 5'd0,  1'b0, 5'd0,  8'h00},
        {5'd0,  5'd9,  1'b1, 5'd0,  8'h00},
        {5'd25, 5'd9,  1'b0, 5'd0,  8'h00},
        {5'd1,  5'd0,  1'b0, 5'd1,  8'h00},
        {5'd1,  5'd10, 1'b1, 5'd10, 8'h77},
        {5'd1,  5'd16, 1'b1, 5'd0,  8'h99},
        {5'd0,  5'd25, 1'b1, 5'd0,  8'h80},
        {5'd12, 5'd25, 1'b1, 5'd0,  8'h81},
        {5'd13, 5'd25, 1'b1, 5'd0,  8'hFF},
        {5'd26, 5'd0,  1'b1, 5'd0,  8'h12},
        {5'd31, 5'd1,  1'b0, 5'd0,  8'h00},
        {5'd14, 5'd24, 1'b0, 5'd25, 8'h00},
        {5'd21, 5'd25, 1'b0, 5'd0,  8'h00},
        {5'd23, 5'd24, 1'b0, 5'd0,  8'h00}
    };

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd15, 5'd16, 5'd17, 5'd24: return "R4";
            5'd1, 5'd2:                       return "R8";
            5'd3, 5'd4, 5'd5, 5'd6:           return "R9";
            5'd7, 5'd8, 5'd9, 5'd10:          return "R10";
            5'd11, 5'd12, 5'd13, 5'd14:       return "R5";
            5'd18, 5'd19, 5'd20, 5'd21:       return "R6";
            5'd22, 5'd23:                     return "R7";
            5'd25:                            return "R11";
            default:                          return "R2";
        endcase
    endfunction

    function automatic int lat_of(input logic [4:0] op);
        if (op == 5'd13 || op == 5'd14) return 3;
        if (op == 5'd0 || (op >= 5'd3 && op <= 5'd10) ||
            (op >= 5'd18 && op <= 5'd21) || op > 5'd25) return 1;
        return 2;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic peek(input int idx, output logic [7:0] v);
        peek_addr = 5'(idx);
        #1;
        v = peek_data;
    endtask

    // reference model built from the requirements
    task automatic model_step(input logic [4:0] op, input logic [4:0] dst,
                              input logic ui, input logic [4:0] src,
                              input logic [7:0] imm);
        logic [7:0] a, b, r;
        logic [8:0] t;
        bit wr, uz;
        a  = m_reg[dst];
        b  = (ui && op != 5'd1) ? imm : m_reg[src];
        r  = a;
        wr = 1'b1;
        uz = 1'b1;
        case (op)
            5'd0:  r = b;
            5'd1:  begin r = b; m_reg[src] = a; end
            5'd2:  r = {a[3:0], a[7:4]};
            5'd3:  r = {7'd0, m_zf};
            5'd4:  r = {7'd0, !m_zf};
            5'd5:  r = {7'd0, m_cf};
            5'd6:  r = {7'd0, !m_cf};
            5'd7:  begin r = m_zf  ? 8'hFF : 8'h00; uz = 1'b0; end
            5'd8:  begin r = !m_zf ? 8'hFF : 8'h00; uz = 1'b0; end
            5'd9:  begin r = m_cf  ? 8'hFF : 8'h00; uz = 1'b0; end
            5'd10: begin r = !m_cf ? 8'hFF : 8'h00; uz = 1'b0; end
            5'd11: begin t = {1'b0, a} + {1'b0, b}; r = t[7:0]; m_cf = t[8]; end
            5'd12: begin t = {1'b0, a} - {1'b0, b}; r = t[7:0]; m_cf = t[8]; end
            5'd13: begin t = {1'b0, a} + {1'b0, b} + {8'd0, m_cf}; r = t[7:0]; m_cf = t[8]; end
            5'd14: begin t = {1'b0, a} - {1'b0, b} - {8'd0, m_cf}; r = t[7:0]; m_cf = t[8]; end
            5'd15: r = a & b;
            5'd16: r = a | b;
            5'd17: r = a ^ b;
            5'd18: begin r = a >> 1; m_cf = a[0]; end
            5'd19: begin r = a << 1; m_cf = a[7]; end
            5'd20: begin r = {a[0], a[7:1]}; m_cf = a[0]; end
            5'd21: begin r = {a[6:0], a[7]}; m_cf = a[7]; end
            5'd22: begin r = {m_cf, a[7:1]}; m_cf = a[0]; end
            5'd23: begin r = {a[6:0], m_cf}; m_cf = a[7]; end
            5'd24: r = ~a;
            5'd25: begin r = 8'd0 - a; m_cf = (r != 8'd0); end
            default: begin wr = 1'b0; uz = 1'b0; end
        endcase
        if (wr) m_reg[dst] = r;
        if (uz) m_zf = (r == 8'd0);
    endtask

    task automatic run_instr(input logic [4:0] op, input logic [4:0] dst,
                             input logic ui, input logic [4:0] src,
                             input logic [7:0] imm);
        int n;
        string rq;
        logic [7:0] v;
        rq = req_of(op);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_dst = dst;
        in_use_imm = ui; in_src = src; in_imm = imm;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        n = 1;
        while (!done && n < 8) begin
            @(negedge clk);
            n++;
        end
        // R2 latency from acceptance to done
        check(n == lat_of(op), "R2", $sformatf("latency op %0d", op), n, lat_of(op));
        model_step(op, dst, ui, src, imm);
        @(negedge clk);
        // R2 done is a single pulse
        check(!done, "R2", "done single cycle", int'(done), 0);
        peek(int'(dst), v);
        check(v == m_reg[dst], rq, $sformatf("op %0d dst r%0d", op, dst), v, m_reg[dst]);
        if (op == 5'd1) begin
            peek(int'(src), v);
            check(v == m_reg[src], "R8", "exchange src", v, m_reg[src]);
        end
        check(zf == m_zf, rq, $sformatf("op %0d zf", op), int'(zf), int'(m_zf));
        check(cf == m_cf, rq, $sformatf("op %0d cf", op), int'(cf), int'(m_cf));
    endtask

    initial begin
        logic [7:0] v;
        bit all_zero;
        for (int i = 0; i < NR; i++) m_reg[i] = 8'd0;
        m_zf = 1'b0;
        m_cf = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        all_zero = 1'b1;
        for (int i = 0; i < NR; i++) begin
            peek(i, v);
            if (v != 8'd0) all_zero = 1'b0;
        end
        check(all_zero, "R1", "registers zero", int'(all_zero), 1);
        check({zf, cf} == 2'b00, "R1", "flags zero", int'({zf, cf}), 0);
        check({busy, done} == 2'b00, "R1", "idle", int'({busy, done}), 0);
        check(in_ready == 1'b1, "R1", "ready", int'(in_ready), 1);

        // table walk (R4..R12)
        for (int k = 0; k < NV; k++) begin
            run_instr(VEC[k][23:19], VEC[k][18:14], VEC[k][13], VEC[k][12:8], VEC[k][7:0]);
        end

        // R3: offer a move while an add is in flight
        @(negedge clk);
        in_valid = 1'b1; in_op = 5'd11; in_dst = 5'd11;
        in_use_imm = 1'b1; in_src = 5'd0; in_imm = 8'h05;
        @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b0, "R3", "not ready while busy", int'(in_ready), 0);
        check(done == 1'b0, "R13", "no done in first of two cycles", int'(done), 0);
        in_op = 5'd0; in_dst = 5'd12; in_imm = 8'h33;
        // R13: destination not written before the done edge
        peek(11, v);
        check(v == m_reg[11], "R13", "dst before commit", v, m_reg[11]);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(done == 1'b1, "R2", "done in cycle two", int'(done), 1);
        model_step(5'd11, 5'd11, 1'b1, 5'd0, 8'h05);
        @(negedge clk);
        peek(11, v);
        check(v == m_reg[11], "R5", "add during busy test", v, m_reg[11]);
        peek(12, v);
        check(v == m_reg[12], "R3", "busy-time move ignored", v, m_reg[12]);
        check(busy == 1'b0, "R3", "idle after test", int'(busy), 0);

        // R12: single-operand op with immediate and src set ignores both
        run_instr(5'd24, 5'd20, 1'b1, 5'd3, 8'hF0);
        run_instr(5'd18, 5'd20, 1'b0, 5'd7, 8'h00);

        // final register sweep against the model (R13 nothing stray written)
        for (int i = 0; i < NR; i++) begin
            peek(i, v);
            check(v == m_reg[i], "R13", $sformatf("final r%0d", i), v, m_reg[i]);
        end

        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule